// File: doc/BRIEF.md
# DRAM Access and Refresh Sequencer

This block sits between an asynchronous processor bus (active-low address strobe, active-low data acknowledge) and an asynchronous DRAM. It turns each DRAM-selected bus cycle into a row/column cycle. It drives the row strobe, a row/column select that steers a multiplexed address, the column strobe and the acknowledge. It also runs periodic refresh cycles of the column-before-row kind, paced by a small refresh step counter. A pulse on the refresh request input stands in for the interval timer, which lies outside this block.

The row strobe for an access follows the falling address strobe combinationally, with no clock edge in between. It is gated by a registered enable. Refresh uses this gate to cut into an access, to follow one, or to start on the same edge as one, and no truncated row pulse results. While a refresh runs, DRAM acknowledge is held off. ROM cycles are acknowledged at once whether or not a refresh is running.

Top module: `dram_refresh_seq`

## Requirements
- R1: While the enable is set and the sequencer is idle, a DRAM cycle (strobeN low, dramSel high) drives rasN low in the same cycle, with no clock edge in between. Raising strobeN releases rasN at once.
- R2: One clock edge after a DRAM cycle starts, rowColSel goes high and memAddr switches from rowAddr to colAddr. On the next edge casN and dtackN go low. All four return to idle when strobeN rises.
- R3: A refresh holds casN low with rasN high for one clock. It then holds both low for RAS_CLKS clocks, releases both together, and holds both high for PRE_CLKS clocks before it returns to idle. The step counter counts up by one through these states and then returns to 0.
- R4: A refresh request pulse is latched at the next edge. If the bus is idle, the refresh starts on the edge after that. Requests that arrive while a refresh runs leave at most one further refresh queued.
- R5: A refresh requested during a DRAM cycle waits until that cycle has been acknowledged. It then starts on an edge that drops the enable, which releases rasN while strobeN is still low. rasN stays high for at least one clock before the refresh drives it low.
- R6: If strobeN is still low when a refresh that followed an acknowledged access ends, the enable stays low until the first edge that sees no DRAM cycle. rasN stays high throughout, and the next DRAM cycle starts normally.
- R7: If a refresh starts on the edge just before strobeN falls, the access gets no rasN until the refresh and its precharge are done. The access then runs the R2 sequence.
- R8: dtackN stays high for DRAM cycles while a refresh runs. For a ROM cycle (strobeN low, romSel high) dtackN is low at once, even during a refresh.
- R9: Every rasN low pulse lasts at least two clocks, less input skew. Every rasN high interval between pulses lasts at least one clock, in all four arbitration cases.
- R10: During reset rasN, casN and dtackN are high and rowColSel is low. The enable comes out of reset set, with no refresh pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rstN | input | 1 | Active-low synchronous reset |
| strobeN | input | 1 | Bus address strobe, active low |
| dramSel | input | 1 | Current bus cycle targets DRAM |
| romSel | input | 1 | Current bus cycle targets ROM |
| refreshReq | input | 1 | One-clock refresh request pulse |
| rowAddr | input | ADDR_W | Row half of the DRAM address |
| colAddr | input | ADDR_W | Column half of the DRAM address |
| rasN | output | 1 | DRAM row strobe, active low |
| casN | output | 1 | DRAM column strobe, active low |
| rowColSel | output | 1 | Low selects row, high selects column address |
| memAddr | output | ADDR_W | Multiplexed DRAM address |
| dtackN | output | 1 | Bus data acknowledge, active low |

## Verification
A step counter that skips or repeats a state shows on the next clock as a row pulse that is too short or too long, or as a column strobe that does not lead the row strobe. An enable that rises too early shows as a row pulse at once, within the same clock, while the strobe is still low. An enable stuck low shows as an access that never gets a row strobe or an acknowledge. A latch that loses or doubles requests shows as one refresh too few or too many within a few clocks of the request.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic rasEnable;  // registered gate for access row strobe
    logic refRas;     // refresh drives row strobe
    logic refCas;     // refresh drives column strobe
    logic colPhase;   // access has reached column address phase
    logic dramAck;    // access has reached column strobe / acknowledge phase
  } seqStrobes_t;
endpackage

// File: rtl/dram_seq_ctrl.sv
module dram_seq_ctrl
  import dram_seq_pkg::*;
#(
  parameter int RAS_CLKS = 2,
  parameter int PRE_CLKS = 1,
  localparam int RS_LAST = 1 + RAS_CLKS + PRE_CLKS,
  localparam int RS_W = $clog2(RS_LAST + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            strobeN,
  input  logic            dramSel,
  input  logic            refreshReq,
  output seqStrobes_t     strobes,
  output logic [RS_W-1:0] rsState
);
  localparam logic [RS_W-1:0] RS_IDLE  = '0;
  localparam logic [RS_W-1:0] RS_FIRST = RS_W'(1);
  localparam logic [RS_W-1:0] RAS_BEG  = RS_W'(2);
  localparam logic [RS_W-1:0] RAS_END  = RS_W'(1 + RAS_CLKS);
  localparam logic [RS_W-1:0] RS_END   = RS_W'(RS_LAST);

  logic [RS_W-1:0] rs;
  logic            rasEn;
  logic            refPend;
  logic [1:0]      accStep;
  logic            accDone;

  logic busAct, accActive, startRef, ackNow, reEnable;

  always_comb begin
    busAct    = !strobeN && dramSel;
    accActive = busAct && rasEn;
    ackNow    = accActive && (accStep == 2'd2);
    startRef  = (rs == RS_IDLE) && refPend && (!busAct || accDone);
    reEnable  = !accDone || !busAct;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rs      <= RS_IDLE;
      rasEn   <= 1'b1;
      refPend <= 1'b0;
      accStep <= 2'd0;
      accDone <= 1'b0;
    end else begin
      refPend <= (refPend && !startRef) || refreshReq;

      if (startRef) begin
        rs    <= RS_FIRST;
        rasEn <= 1'b0;
      end else if (rs == RS_END) begin
        rs    <= RS_IDLE;
        rasEn <= reEnable;
      end else if (rs != RS_IDLE) begin
        rs <= rs + 1'b1;
      end else if (!rasEn) begin
        rasEn <= reEnable;
      end

      if (!accActive || startRef) accStep <= 2'd0;
      else if (accStep != 2'd2)   accStep <= accStep + 2'd1;

      if (!busAct)     accDone <= 1'b0;
      else if (ackNow) accDone <= 1'b1;
    end
  end

  always_comb begin
    strobes.rasEnable = rasEn;
    strobes.refCas    = (rs >= RS_FIRST) && (rs <= RAS_END);
    strobes.refRas    = (rs >= RAS_BEG) && (rs <= RAS_END);
    strobes.colPhase  = (accStep != 2'd0);
    strobes.dramAck   = (accStep == 2'd2);
    rsState           = rs;
  end
endmodule

// File: rtl/dram_seq_datapath.sv
module dram_seq_datapath
  import dram_seq_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              strobeN,
  input  logic              dramSel,
  input  logic              romSel,
  input  logic [ADDR_W-1:0] rowAddr,
  input  logic [ADDR_W-1:0] colAddr,
  input  seqStrobes_t       strobes,
  output logic              rasN,
  output logic              casN,
  output logic              rowColSel,
  output logic [ADDR_W-1:0] memAddr,
  output logic              dtackN
);
  logic accLive, romAck, dramAckLive;

  always_comb begin
    accLive     = !strobeN && dramSel && strobes.rasEnable;
    romAck      = !strobeN && romSel;
    dramAckLive = accLive && strobes.dramAck;
    rasN        = !(accLive || strobes.refRas);
    casN        = !(dramAckLive || strobes.refCas);
    rowColSel   = accLive && strobes.colPhase;
    memAddr     = rowColSel ? colAddr : rowAddr;
    dtackN      = !(romAck || dramAckLive);
  end
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_seq_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int RAS_CLKS = 2,
  parameter int PRE_CLKS = 1,
  localparam int RS_W = $clog2(2 + RAS_CLKS + PRE_CLKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strobeN,
  input  logic              dramSel,
  input  logic              romSel,
  input  logic              refreshReq,
  input  logic [ADDR_W-1:0] rowAddr,
  input  logic [ADDR_W-1:0] colAddr,
  output logic              rasN,
  output logic              casN,
  output logic              rowColSel,
  output logic [ADDR_W-1:0] memAddr,
  output logic              dtackN
);
  seqStrobes_t     strobes;
  logic [RS_W-1:0] rsState;

  dram_seq_ctrl #(.RAS_CLKS(RAS_CLKS), .PRE_CLKS(PRE_CLKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .strobeN(strobeN), .dramSel(dramSel),
    .refreshReq(refreshReq), .strobes(strobes), .rsState(rsState)
  );

  dram_seq_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .strobeN(strobeN), .dramSel(dramSel), .romSel(romSel),
    .rowAddr(rowAddr), .colAddr(colAddr), .strobes(strobes),
    .rasN(rasN), .casN(casN), .rowColSel(rowColSel),
    .memAddr(memAddr), .dtackN(dtackN)
  );
endmodule

// File: rtl/dram_seq_checker.sv
module dram_seq_checker #(
  parameter int RAS_CLKS = 2,
  parameter int PRE_CLKS = 1,
  localparam int RS_LAST = 1 + RAS_CLKS + PRE_CLKS,
  localparam int RS_W = $clog2(RS_LAST + 1)
) (
  input logic            clk,
  input logic            rstN,
  input logic            romSel,
  input logic            rasN,
  input logic            casN,
  input logic            dtackN,
  input logic            rowColSel,
  input logic [RS_W-1:0] rsState
);
  localparam logic [RS_W-1:0] RS_END  = RS_W'(RS_LAST);
  localparam logic [RS_W-1:0] RAS_BEG = RS_W'(2);
  localparam logic [RS_W-1:0] RAS_END = RS_W'(1 + RAS_CLKS);

  AST_RS_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (rsState != '0 && rsState != RS_END) |=> rsState == $past(rsState) + 1'b1); // R3
  AST_RS_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (rsState == RS_END) |=> rsState == '0); // R3
  AST_CBR_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    (rsState == RAS_BEG) |-> $past(!casN && rasN)); // R3
  AST_REF_BOTH_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (rsState >= RAS_BEG && rsState <= RAS_END) |-> (!rasN && !casN)); // R3
  AST_NO_DRAM_ACK_REFRESH: assert property (@(posedge clk) disable iff (!rstN)
    (rsState != '0 && !romSel) |-> dtackN); // R8
  AST_SEL_WITH_RAS: assert property (@(posedge clk) disable iff (!rstN)
    rowColSel |-> !rasN); // R2
endmodule

bind dram_refresh_seq dram_seq_checker #(.RAS_CLKS(RAS_CLKS), .PRE_CLKS(PRE_CLKS)) u_chk (
  .clk(clk), .rstN(rstN), .romSel(romSel), .rasN(rasN), .casN(casN),
  .dtackN(dtackN), .rowColSel(rowColSel), .rsState(rsState)
);

// File: tb/tb_dram_refresh_seq.sv
`timescale 1ns/1ps
module tb_dram_refresh_seq;
  localparam int ADDR_W = 10;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic strobeN = 1'b1, dramSel = 1'b0, romSel = 1'b0, refreshReq = 1'b0;
  logic [ADDR_W-1:0] rowAddr = 10'h0A5, colAddr = 10'h13C;
  logic rasN, casN, rowColSel, dtackN;
  logic [ADDR_W-1:0] memAddr;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dram_refresh_seq #(.ADDR_W(ADDR_W), .RAS_CLKS(2), .PRE_CLKS(1)) dut (
    .clk(clk), .rstN(rstN), .strobeN(strobeN), .dramSel(dramSel), .romSel(romSel),
    .refreshReq(refreshReq), .rowAddr(rowAddr), .colAddr(colAddr),
    .rasN(rasN), .casN(casN), .rowColSel(rowColSel), .memAddr(memAddr), .dtackN(dtackN)
  );

  // vector: {strobeN, dramSel, romSel, refreshReq, rasN, casN, rowColSel, dtackN, tag}
  localparam int NV = 29;
  localparam logic [11:0] VEC [0:NV-1] = '{
    // idle DRAM access: R1, R2
    12'b0100_0101_0001, 12'b0100_0111_0010, 12'b0100_0010_0010,
    12'b1000_1101_0001, 12'b1000_1101_0001,
    // idle refresh: R4 latch, R3 sequence
    12'b1001_1101_0100, 12'b1000_1101_0100, 12'b1000_1001_0011,
    12'b1000_0001_0011, 12'b1000_0001_0011, 12'b1000_1101_0011,
    12'b1000_1101_0011,
    // concurrent start: R7
    12'b1001_1101_0111, 12'b1000_1101_0111, 12'b0100_1001_0111,
    12'b0100_0001_0111, 12'b0100_0001_0111, 12'b0100_1101_0111,
    12'b0100_0101_0111, 12'b0100_0111_0111, 12'b0100_0010_0111,
    12'b1000_1101_0111,
    // ROM during refresh: R8
    12'b1001_1101_1000, 12'b1000_1101_1000, 12'b0010_1000_1000,
    12'b1000_0001_1000, 12'b1000_0001_1000, 12'b1000_1101_1000,
    12'b1000_1101_1000
  };

  function automatic string tagName(input logic [3:0] t);
    case (t)
      4'd1: return "R1"; 4'd2: return "R2"; 4'd3: return "R3"; 4'd4: return "R4";
      4'd5: return "R5"; 4'd6: return "R6"; 4'd7: return "R7"; 4'd8: return "R8";
      4'd9: return "R9"; default: return "R10";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [3:0] expv);
    logic [3:0] act;
    act = {rasN, casN, rowColSel, dtackN};
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s at %0t: {ras,cas,sel,dtack} actual %b expected %b", tag, $time, act, expv);
    end
  endtask

  task automatic chkAddr(input string tag, input logic [ADDR_W-1:0] expv);
    checks++;
    if (memAddr !== expv) begin
      errors++;
      $display("FAIL %s at %0t: memAddr actual %h expected %h", tag, $time, memAddr, expv);
    end
  endtask

  // advance to just after a clock edge, drive, then settle
  task automatic step(input logic s, input logic d, input logic r, input logic q);
    @(posedge clk);
    #2;
    strobeN = s; dramSel = d; romSel = r; refreshReq = q;
    #1;
  endtask

  // R9: row strobe pulse width monitor (ns)
  realtime tFall = 0, tRise = 0;
  bit seenRise = 1'b0;
  always @(rasN) begin
    if (rstN) begin
      if (rasN === 1'b1) begin
        tRise = $realtime; seenRise = 1'b1;
        checks++;
        if (tRise - tFall < 18.0) begin
          errors++;
          $display("FAIL R9: rasN low width actual %0t expected >= 18ns", tRise - tFall);
        end
      end else if (rasN === 1'b0) begin
        tFall = $realtime;
        if (seenRise) begin
          checks++;
          if (tFall - tRise < 8.0) begin
            errors++;
            $display("FAIL R9: rasN precharge actual %0t expected >= 8ns", tFall - tRise);
          end
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int cbr;
    // R10: reset state
    repeat (3) @(posedge clk);
    #3 chk("R10", 4'b1101);
    @(posedge clk); #2 rstN = 1'b1;
    #1 chk("R10", 4'b1101);

    // table walk
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][11], VEC[i][10], VEC[i][9], VEC[i][8]);
      chk(tagName(VEC[i][3:0]), VEC[i][7:4]);
    end

    // R5 / R6: refresh after an acknowledged access with strobe held low
    step(0, 1, 0, 0); chk("R1", 4'b0101); chkAddr("R2", rowAddr);
    step(0, 1, 0, 0); chk("R2", 4'b0111); chkAddr("R2", colAddr);
    step(0, 1, 0, 1); chk("R2", 4'b0010);
    step(0, 1, 0, 0); chk("R5", 4'b0010);
    step(0, 1, 0, 0); chk("R5", 4'b1001);   // enable drop releases rasN
    step(0, 1, 0, 0); chk("R5", 4'b0001);
    step(0, 1, 0, 0); chk("R5", 4'b0001);
    step(0, 1, 0, 0); chk("R5", 4'b1101);
    step(0, 1, 0, 0); chk("R6", 4'b1101);   // held off, strobe still low
    step(1, 0, 0, 0); chk("R6", 4'b1101);
    step(0, 1, 0, 0); chk("R6", 4'b0101);   // normal access resumes
    step(0, 1, 0, 0); chk("R6", 4'b0111);
    step(0, 1, 0, 0); chk("R6", 4'b0010);
    step(1, 0, 0, 0); chk("R1", 4'b1101);
    step(1, 0, 0, 0);

    // R4: requests during a refresh queue only one more
    cbr = 0;
    step(1, 0, 0, 1); if (!casN && rasN) cbr++;
    step(1, 0, 0, 0); if (!casN && rasN) cbr++;
    step(1, 0, 0, 0); if (!casN && rasN) cbr++;
    step(1, 0, 0, 1); if (!casN && rasN) cbr++;
    step(1, 0, 0, 1); if (!casN && rasN) cbr++;
    for (int k = 0; k < 14; k++) begin
      step(1, 0, 0, 0); if (!casN && rasN) cbr++;
    end
    checks++;
    if (cbr != 2) begin
      errors++;
      $display("FAIL R4: refresh count actual %0d expected 2", cbr);
    end
    chk("R4", 4'b1101);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule